// File: doc/BRIEF.md
# I2C Controller Status Flag Unit

This block keeps the status flags of an I2C controller and presents them as one 32-bit status word on a small register port. The controller core feeds it one-cycle event pulses (START seen, STOP seen, own address matched, general call, arbitration lost, NACK received, bus error, timeout, byte shifted in, data register read). It also feeds level inputs for transmitter mode and transmit-register-empty. The block turns these into sticky flags. Some flags clear when software reads the status word. Others clear when software writes a 1 to them.

Beside the event flags, the unit watches the raw SDA and SCL lines through a synchronizer to track bus occupancy. It also tracks whether the controller holds the master role, and whether the receive data register holds one or two unread bytes. Software reads the word through `reg_rdata_o`, which always shows the current status. A read strobe or write strobe counts only when `reg_addr_i` equals the status address.

Top module: `i2c_stat_unit`

## Requirements
- R1: After reset, with `is_tx_i` and `txde_i` low, the status word reads 0x0000_0000.
- R2: START (bit 0), STOP (bit 1), address match (bit 2) and general call (bit 3) become 1 one cycle after their event pulse. They clear one cycle after a read strobe to the status address. An event that arrives in the same cycle as that read stays set.
- R3: Arbitration lost (bit 8), NACK (bit 9), bus error (bit 10) and timeout (bit 11) become 1 one cycle after their event pulse. A write to the status address clears only the bits where the write data holds a 1. A set event in the same cycle as the clear wins.
- R4: A status read leaves bits 11..8 unchanged. A status write leaves bits 3..0 unchanged. A read to any other address clears nothing.
- R5: Bit 21 follows `is_tx_i` (1 = transmitter) and bit 17 follows `txde_i`, both in the same cycle.
- R6: While enabled, bus-busy (bit 19) becomes 1 three cycles after SDA or SCL is driven low. It becomes 0 three cycles after SDA rises while SCL is high (a STOP).
- R7: While `en_i` is low, bus-busy and master (bit 20) read 0, whatever the lines do.
- R8: A target-address write while enabled and bus-busy is 0 sets master one cycle later. The same write while bus-busy is 1 has no effect. Master clears one cycle after `stop_sent_i` or `bus_err_i`.
- R9: Bit 16 (data register holds a byte) sets one cycle after a received byte. Bit 18 (buffer full) sets when a byte completes while bit 16 is already 1. A data register read clears bit 18 if it is set, and otherwise clears bit 16. A byte and a read in the same cycle leave bit 16 at 1.
- R10: Bits 31..22, 15..12 and 7..4 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Controller enable |
| sda_i | input | 1 | Raw SDA line level |
| scl_i | input | 1 | Raw SCL line level |
| tar_wr_i | input | 1 | Target address written (master request) |
| stop_sent_i | input | 1 | Core issued a STOP |
| is_tx_i | input | 1 | Core in transmitter mode |
| txde_i | input | 1 | Transmit data register empty |
| start_ev_i | input | 1 | START detected pulse |
| stop_ev_i | input | 1 | STOP detected pulse |
| addr_ev_i | input | 1 | Own address matched pulse |
| gcall_ev_i | input | 1 | General call received pulse |
| arb_ev_i | input | 1 | Arbitration lost pulse |
| nack_ev_i | input | 1 | NACK received pulse |
| bus_err_i | input | 1 | Bus error pulse |
| tout_ev_i | input | 1 | Timeout pulse |
| byte_rx_i | input | 1 | Shift register completed a byte |
| data_rd_i | input | 1 | Software read of the data register |
| reg_rd_i | input | 1 | Register read strobe |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Register address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Status word |

## Verification
Event flags, master and the receive tracker change one cycle after their strobe. The bench drives each strobe on a falling edge and samples one nanosecond after the next rising edge. Bus-busy passes through two synchronizer flops and one state flop, so it is due three rising edges after a line change. The bench samples it after the second edge, where it must not have moved yet, and again after the third. Transmitter mode and register-empty have no register on the way, so they are checked in the cycle their input changes.

// File: rtl/i2c_stat_pkg.sv
package i2c_stat_pkg;
  localparam int unsigned WORD_W   = 32;
  localparam int unsigned RC_N     = 4;
  localparam int unsigned W1C_N    = 4;
  localparam int unsigned RC_LSB   = 0;
  localparam int unsigned W1C_LSB  = 8;
  localparam int unsigned B_RXDNE  = 16;
  localparam int unsigned B_TXDE   = 17;
  localparam int unsigned B_RXBF   = 18;
  localparam int unsigned B_BUSY   = 19;
  localparam int unsigned B_MASTER = 20;
  localparam int unsigned B_TXNRX  = 21;
endpackage

// File: rtl/i2c_bus_mon.sv
module i2c_bus_mon #(
  parameter int unsigned SYNC_W = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic sda_i,
  input  logic scl_i,
  output logic busy_o
);
  logic [SYNC_W-1:0] sda_q, scl_q;
  logic sda_d, busy_q;
  logic sda_s, scl_s, stop_det;

  generate
    if (SYNC_W == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) begin
          sda_q <= '1;
          scl_q <= '1;
        end else begin
          sda_q <= sda_i;
          scl_q <= scl_i;
        end
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) begin
          sda_q <= '1;
          scl_q <= '1;
        end else begin
          sda_q <= {sda_q[SYNC_W-2:0], sda_i};
          scl_q <= {scl_q[SYNC_W-2:0], scl_i};
        end
    end
  endgenerate

  assign sda_s    = sda_q[SYNC_W-1];
  assign scl_s    = scl_q[SYNC_W-1];
  // STOP: SDA low-to-high with SCL high
  assign stop_det = sda_s & ~sda_d & scl_s;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      sda_d  <= 1'b1;
      busy_q <= 1'b0;
    end else begin
      sda_d  <= sda_s;
      if (!en_i) busy_q <= 1'b0;
      else       busy_q <= (busy_q | ~sda_s | ~scl_s) & ~stop_det;
    end

  assign busy_o = busy_q;
endmodule

// File: rtl/i2c_evt_flags.sv
module i2c_evt_flags #(
  parameter int unsigned N           = 4,
  parameter bit          CLR_ON_READ = 1'b1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic         rd_hit_i,
  input  logic         wr_hit_i,
  input  logic [N-1:0] wdata_i,
  output logic [N-1:0] q_o
);
  logic [N-1:0] q, clr;

  generate
    if (CLR_ON_READ) begin : g_rc
      assign clr = {N{rd_hit_i}};
    end else begin : g_w1c
      assign clr = wdata_i & {N{wr_hit_i}};
    end
  endgenerate

  // set wins over a clear in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) q <= '0;
    else         q <= (q & ~clr) | set_i;

  assign q_o = q;
endmodule

// File: rtl/i2c_rx_track.sv
module i2c_rx_track (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic byte_rx_i,
  input  logic data_rd_i,
  output logic dne_o,
  output logic full_o
);
  logic dne_q, full_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      dne_q  <= 1'b0;
      full_q <= 1'b0;
    end else begin
      dne_q  <= byte_rx_i | (dne_q & (~data_rd_i | full_q));
      full_q <= full_q ? ~(data_rd_i & ~byte_rx_i)
                       : (byte_rx_i & dne_q & ~data_rd_i);
    end

  assign dne_o  = dne_q;
  assign full_o = full_q;
endmodule

// File: rtl/i2c_stat_unit.sv
module i2c_stat_unit
  import i2c_stat_pkg::*;
#(
  parameter int unsigned ADDR_W    = 4,
  parameter int unsigned STAT_ADDR = 3,
  parameter int unsigned SYNC_W    = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              sda_i,
  input  logic              scl_i,
  input  logic              tar_wr_i,
  input  logic              stop_sent_i,
  input  logic              is_tx_i,
  input  logic              txde_i,
  input  logic              start_ev_i,
  input  logic              stop_ev_i,
  input  logic              addr_ev_i,
  input  logic              gcall_ev_i,
  input  logic              arb_ev_i,
  input  logic              nack_ev_i,
  input  logic              bus_err_i,
  input  logic              tout_ev_i,
  input  logic              byte_rx_i,
  input  logic              data_rd_i,
  input  logic              reg_rd_i,
  input  logic              reg_wr_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [WORD_W-1:0] reg_wdata_i,
  output logic [WORD_W-1:0] reg_rdata_o
);
  localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_ADDR);

  logic              addr_hit, rd_hit, wr_hit;
  logic              busy, rx_dne, rx_full;
  logic              master_q;
  logic [RC_N-1:0]   rc_q;
  logic [W1C_N-1:0]  w1c_q;
  logic [WORD_W-1:0] word;

  assign addr_hit = (reg_addr_i == STAT_A);
  assign rd_hit   = reg_rd_i & addr_hit;
  assign wr_hit   = reg_wr_i & addr_hit;

  i2c_bus_mon #(.SYNC_W(SYNC_W)) u_mon (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (en_i),
    .sda_i (sda_i),
    .scl_i (scl_i),
    .busy_o(busy)
  );

  i2c_evt_flags #(.N(RC_N), .CLR_ON_READ(1'b1)) u_rc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .set_i   ({gcall_ev_i, addr_ev_i, stop_ev_i, start_ev_i}),
    .rd_hit_i(rd_hit),
    .wr_hit_i(wr_hit),
    .wdata_i (reg_wdata_i[RC_LSB +: RC_N]),
    .q_o     (rc_q)
  );

  i2c_evt_flags #(.N(W1C_N), .CLR_ON_READ(1'b0)) u_w1c (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .set_i   ({tout_ev_i, bus_err_i, nack_ev_i, arb_ev_i}),
    .rd_hit_i(rd_hit),
    .wr_hit_i(wr_hit),
    .wdata_i (reg_wdata_i[W1C_LSB +: W1C_N]),
    .q_o     (w1c_q)
  );

  i2c_rx_track u_rx (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .byte_rx_i(byte_rx_i),
    .data_rd_i(data_rd_i),
    .dne_o    (rx_dne),
    .full_o   (rx_full)
  );

  // master role: clear terms dominate the request
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)                             master_q <= 1'b0;
    else if (!en_i || stop_sent_i || bus_err_i) master_q <= 1'b0;
    else if (tar_wr_i && !busy)              master_q <= 1'b1;

  always_comb begin
    word                       = '0;
    word[RC_LSB +: RC_N]       = rc_q;
    word[W1C_LSB +: W1C_N]     = w1c_q;
    word[B_RXDNE]              = rx_dne;
    word[B_TXDE]               = txde_i;
    word[B_RXBF]               = rx_full;
    word[B_BUSY]               = busy;
    word[B_MASTER]             = master_q;
    word[B_TXNRX]              = is_tx_i;
  end

  assign reg_rdata_o = word;
endmodule

// File: rtl/i2c_stat_unit_chk.sv
module i2c_stat_unit_chk #(
  parameter int unsigned ADDR_W    = 4,
  parameter int unsigned STAT_ADDR = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              en_i,
  input logic              tar_wr_i,
  input logic              start_ev_i,
  input logic              arb_ev_i,
  input logic              reg_rd_i,
  input logic              reg_wr_i,
  input logic [ADDR_W-1:0] reg_addr_i,
  input logic [31:0]       reg_wdata_i,
  input logic [31:0]       reg_rdata_o
);
  logic rd_s, wr_s;
  assign rd_s = reg_rd_i && (reg_addr_i == ADDR_W'(STAT_ADDR));
  assign wr_s = reg_wr_i && (reg_addr_i == ADDR_W'(STAT_ADDR));

  a_r2_read_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_s && !start_ev_i) |=> !reg_rdata_o[0]);
  a_r2_event_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_ev_i |=> reg_rdata_o[0]);
  a_r3_w1c_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_s && reg_wdata_i[8] && !arb_ev_i) |=> !reg_rdata_o[8]);
  a_r3_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arb_ev_i |=> reg_rdata_o[8]);
  a_r4_read_keeps_w1c: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_s) |=> (reg_rdata_o[8] || !$past(reg_rdata_o[8])));
  a_r7_disable_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!reg_rdata_o[19] && !reg_rdata_o[20]));
  a_r8_master_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(reg_rdata_o[20]) |-> ($past(tar_wr_i) && !$past(reg_rdata_o[19])));
  a_r9_full_needs_dne: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_rdata_o[18] |-> reg_rdata_o[16]);
endmodule

bind i2c_stat_unit i2c_stat_unit_chk #(.ADDR_W(ADDR_W), .STAT_ADDR(STAT_ADDR)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .en_i       (en_i),
  .tar_wr_i   (tar_wr_i),
  .start_ev_i (start_ev_i),
  .arb_ev_i   (arb_ev_i),
  .reg_rd_i   (reg_rd_i),
  .reg_wr_i   (reg_wr_i),
  .reg_addr_i (reg_addr_i),
  .reg_wdata_i(reg_wdata_i),
  .reg_rdata_o(reg_rdata_o)
);

// File: tb/i2c_stat_unit_tb_top.sv
module i2c_stat_unit_tb_top;
  localparam int ADDR_W = 4;
  localparam logic [ADDR_W-1:0] SA = 4'd3;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic en = 0, sda = 1, scl = 1, tar_wr = 0, stop_sent = 0, is_tx = 0, txde = 0;
  logic [9:0] ev = '0;  // [0]start [1]stop [2]addr [3]gcall [4]arb [5]nack [6]berr [7]tout [8]byte_rx [9]data_rd
  logic rd = 0, wr = 0;
  logic [ADDR_W-1:0] addr = SA;
  logic [31:0] wd = '0, rdata;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  i2c_stat_unit #(.ADDR_W(ADDR_W), .STAT_ADDR(3)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .en_i(en), .sda_i(sda), .scl_i(scl),
    .tar_wr_i(tar_wr), .stop_sent_i(stop_sent), .is_tx_i(is_tx), .txde_i(txde),
    .start_ev_i(ev[0]), .stop_ev_i(ev[1]), .addr_ev_i(ev[2]), .gcall_ev_i(ev[3]),
    .arb_ev_i(ev[4]), .nack_ev_i(ev[5]), .bus_err_i(ev[6]), .tout_ev_i(ev[7]),
    .byte_rx_i(ev[8]), .data_rd_i(ev[9]),
    .reg_rd_i(rd), .reg_wr_i(wr), .reg_addr_i(addr), .reg_wdata_i(wd),
    .reg_rdata_o(rdata)
  );

  typedef struct packed {
    logic [9:0]  ev;
    logic        rd;
    logic        wr;
    logic [31:0] wd;
    logic [31:0] exp;
  } vec_t;

  localparam int NV = 24;
  localparam vec_t VT [NV] = '{
    '{10'h001, 0, 0, 32'h0,        32'h0000_0001}, // R2 start
    '{10'h00C, 0, 0, 32'h0,        32'h0000_000D}, // R2 addr+gcall
    '{10'h000, 1, 0, 32'h0,        32'h0000_0000}, // R2 read clears
    '{10'h001, 1, 0, 32'h0,        32'h0000_0001}, // R2 event in read cycle kept
    '{10'h000, 1, 0, 32'h0,        32'h0000_0000}, // R2
    '{10'h030, 0, 0, 32'h0,        32'h0000_0300}, // R3 arb+nack
    '{10'h0C0, 0, 0, 32'h0,        32'h0000_0F00}, // R3 berr+tout
    '{10'h000, 0, 1, 32'h0000_0100, 32'h0000_0E00}, // R3 per-bit clear
    '{10'h020, 0, 1, 32'h0000_0200, 32'h0000_0E00}, // R3 set wins
    '{10'h000, 0, 1, 32'hFFFF_FFFF, 32'h0000_0000}, // R3 all clear
    '{10'h002, 0, 0, 32'h0,        32'h0000_0002}, // R2 stop
    '{10'h000, 0, 1, 32'h0000_000F, 32'h0000_0002}, // R4 write keeps RC
    '{10'h000, 1, 0, 32'h0,        32'h0000_0000}, // R2
    '{10'h010, 0, 0, 32'h0,        32'h0000_0100}, // R3 arb
    '{10'h000, 1, 0, 32'h0,        32'h0000_0100}, // R4 read keeps W1C
    '{10'h000, 0, 1, 32'h0000_0100, 32'h0000_0000}, // R3
    '{10'h100, 0, 0, 32'h0,        32'h0001_0000}, // R9 byte -> dne
    '{10'h100, 0, 0, 32'h0,        32'h0005_0000}, // R9 second byte -> full
    '{10'h200, 0, 0, 32'h0,        32'h0001_0000}, // R9 read clears full
    '{10'h200, 0, 0, 32'h0,        32'h0000_0000}, // R9 read clears dne
    '{10'h300, 0, 0, 32'h0,        32'h0001_0000}, // R9 byte+read, empty
    '{10'h300, 0, 0, 32'h0,        32'h0001_0000}, // R9 byte+read, holding
    '{10'h200, 0, 0, 32'h0,        32'h0000_0000}, // R9
    '{10'h000, 1, 1, 32'h0,        32'h0000_0000}  // R10 reserved
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic pulse_step();
    @(posedge clk); #1;
  endtask

  task automatic idle();
    @(negedge clk);
    ev = '0; rd = 0; wr = 0; wd = '0; tar_wr = 0; stop_sent = 0; addr = SA;
  endtask

  initial begin
    #200000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset word", rdata, 32'h0);
    rst_ni = 1;
    idle();
    chk("R1 after release", rdata, 32'h0);

    for (int i = 0; i < NV; i++) begin
      ev = VT[i].ev; rd = VT[i].rd; wr = VT[i].wr; wd = VT[i].wd;
      pulse_step();
      chk($sformatf("vector %0d (R2/R3/R4/R9/R10)", i), rdata, VT[i].exp);
      idle();
    end

    // R4: read to another address clears nothing
    ev = 10'h001; pulse_step(); idle();
    addr = 4'd5; rd = 1; pulse_step();
    chk("R4 foreign read", rdata, 32'h1);
    idle(); rd = 1; pulse_step(); idle();

    // R5 combinational mirrors
    is_tx = 1; txde = 1; #1;
    chk("R5 txnrx/txde", rdata, 32'h0022_0000);
    is_tx = 0; txde = 0; #1;
    chk("R5 low", rdata, 32'h0);

    // R7: lines low while disabled
    sda = 0; repeat (4) pulse_step();
    chk("R7 busy gated", rdata, 32'h0);
    sda = 1; repeat (4) @(negedge clk);

    // R8: master request while idle
    en = 1; repeat (3) @(negedge clk);
    tar_wr = 1; pulse_step();
    chk("R8 master set", rdata, 32'h0010_0000);
    idle(); stop_sent = 1; pulse_step();
    chk("R8 stop_sent clears", rdata, 32'h0);
    idle();

    // R6: busy after SCL low, 3 edges
    scl = 0; pulse_step(); pulse_step();
    chk("R6 busy not yet", rdata, 32'h0);
    pulse_step();
    chk("R6 busy on scl low", rdata, 32'h0008_0000);
    @(negedge clk); sda = 0; @(negedge clk); scl = 1;
    repeat (4) @(negedge clk);
    // R8: request blocked while busy
    tar_wr = 1; pulse_step();
    chk("R8 blocked when busy", rdata, 32'h0008_0000);
    idle();
    sda = 1; pulse_step(); pulse_step();
    chk("R6 stop not yet", rdata, 32'h0008_0000);
    pulse_step();
    chk("R6 stop clears busy", rdata, 32'h0);
    idle();

    // R8: bus error drops master (also sets bit 10)
    tar_wr = 1; pulse_step(); idle();
    ev[6] = 1; pulse_step();
    chk("R8 bus error clears", rdata, 32'h0000_0400);
    idle(); wr = 1; wd = 32'h400; pulse_step(); idle();

    // R7: disable drops busy and master
    tar_wr = 1; pulse_step(); idle();
    sda = 0; repeat (3) pulse_step();
    chk("R7 pre busy+master", rdata, 32'h0018_0000);
    en = 0; pulse_step();
    chk("R7 disable clears", rdata, 32'h0);
    sda = 1;
    idle(); idle();

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule